// File: doc/BRIEF.md
# March-Test Self-Test Controller for a Word-Wide RAM

This block is a fixed-function self-test engine that sits between a small RAM and the logic that normally uses it. While idle it is transparent: the functional address, write data and write enable pass straight to the RAM, and the RAM's read data passes straight back. When `start` is raised, it takes over the RAM through an internal collar multiplexer. It then walks a fixed march algorithm: a six-element coupling-fault march on solid all-zero and all-one words, followed by two elements with alternating patterns inside each word. Every read it issues is checked against the value it expects to find.

The RAM is assumed to return read data one cycle after the address is presented. The controller therefore compares each read in the cycle after the read is issued. A single sticky `fail` flag collects all mismatches. `done` marks the end of the run and holds until `start` is released. Word count and word width are parameters; the four in-word patterns are derived from the word width.

Top module: `march_bist`

## Requirements
- R1: After reset, `done` and `fail` are 0 and the RAM-side address, write data and write enable follow the functional inputs.
- R2: Outside a test run, `mem_addr`, `mem_wdata` and `mem_we` equal `func_addr`, `func_wdata` and `func_we`. At all times `func_rdata` equals `mem_rdata`. During a run, the functional inputs have no effect on the RAM-side outputs.
- R3: A run issues eight elements in this order: write 0; read 0 then write 1; read 1 then write 0; read 0 then write 1; read 1 then write 0; read 0; then write A, read A, write ~A, read ~A; then write B, read B, write ~B, read ~B. The RAM is driven in exactly one operation per cycle, with `mem_we`=1 for writes and 0 for reads.
- R4: Elements 4 and 5 (the third and fourth read-write elements) step the address downward from the top word to 0. Every other element steps upward from 0 to the top word. All operations of an element finish at one address before the address changes.
- R5: Value 0 is the all-zero word and value 1 is the all-ones word. A has bit i set when i is even (0101 for four bits). B has bit i set when i mod 4 is 0 or 1 (0011 for four bits).
- R6: The read data returned one cycle after each read is compared with the value that read expects. A mismatch sets `fail` at the clock edge that ends the compare cycle.
- R7: `fail` stays set until the clock edge at which a new `start` is accepted, and it is cleared at that edge.
- R8: With 18 operations per address and D words, `done` rises D*18+2 edges after the edge that accepts `start`. It stays high while `start` is held and drops at the first edge after `start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a run when idle; hold until `done`, then release |
| func_addr | input | ADDR_W | Functional address |
| func_wdata | input | DATA_W | Functional write data |
| func_we | input | 1 | Functional write enable |
| func_rdata | output | DATA_W | Read data returned to the functional side |
| mem_addr | output | ADDR_W | Address to the RAM |
| mem_wdata | output | DATA_W | Write data to the RAM |
| mem_we | output | 1 | Write enable to the RAM |
| mem_rdata | input | DATA_W | Registered read data from the RAM |
| done | output | 1 | Run finished |
| fail | output | 1 | Sticky mismatch flag |

## Verification
Collar outputs are combinational, so the bench samples them on the falling edge that follows each rising edge. The k-th operation of a run appears after the k-th edge counted from the start edge. A mismatch on read k appears on `fail` after edge k+2, so the stuck-bit and in-word faults are checked at exactly those two cycle indices: low one cycle before, high on the cycle due. `done` is checked to be low after edge D*18+1 and high after edge D*18+2. `fail` is checked to be cleared on the first cycle of a new run.

// File: rtl/march_bist.sv
module march_bist #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] func_addr,
  input  logic [DATA_W-1:0] func_wdata,
  input  logic              func_we,
  output logic [DATA_W-1:0] func_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              fail
);

  localparam logic [ADDR_W-1:0] ATOP = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] AONE = ADDR_W'(1);
  localparam logic [2:0] ELAST = 3'd7;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN, S_FIN} state_t;

  state_t            state;
  logic [2:0]        elem;
  logic [1:0]        step;
  logic [ADDR_W-1:0] addr;
  logic              rd_pend;
  logic [DATA_W-1:0] exp_q;
  logic              fail_q;

  logic              op_wr, op_last;
  logic [2:0]        op_pat;
  logic [2:0]        elem_nx;

  function automatic logic [DATA_W-1:0] pattern(input logic [2:0] code);
    logic [DATA_W-1:0] p;
    for (int i = 0; i < DATA_W; i++) begin
      case (code)
        3'd0:    p[i] = 1'b0;
        3'd1:    p[i] = 1'b1;
        3'd2:    p[i] = (i % 2) == 0;
        3'd3:    p[i] = (i % 2) == 1;
        3'd4:    p[i] = (i % 4) < 2;
        default: p[i] = (i % 4) >= 2;
      endcase
    end
    return p;
  endfunction

  function automatic logic is_down(input logic [2:0] e);
    return (e == 3'd3) || (e == 3'd4);
  endfunction

  always_comb begin
    op_wr   = 1'b0;
    op_pat  = 3'd0;
    op_last = 1'b0;
    case (elem)
      3'd0: begin op_wr = 1'b1; op_last = 1'b1; end
      3'd1, 3'd3: begin
        op_wr   = step[0];
        op_pat  = {2'b00, step[0]};
        op_last = step[0];
      end
      3'd2, 3'd4: begin
        op_wr   = step[0];
        op_pat  = {2'b00, ~step[0]};
        op_last = step[0];
      end
      3'd5: op_last = 1'b1;
      3'd6: begin
        op_wr   = ~step[0];
        op_pat  = {2'b01, step[1]};
        op_last = &step;
      end
      default: begin
        op_wr   = ~step[0];
        op_pat  = {2'b10, step[1]};
        op_last = &step;
      end
    endcase
  end

  wire addr_end = is_down(elem) ? (addr == '0) : (addr == ATOP);
  wire in_test  = (state == S_RUN) || (state == S_DRAIN);
  assign elem_nx = elem + 3'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      elem    <= '0;
      step    <= '0;
      addr    <= '0;
      rd_pend <= 1'b0;
      exp_q   <= '0;
      fail_q  <= 1'b0;
    end else begin
      rd_pend <= (state == S_RUN) && !op_wr;
      exp_q   <= pattern(op_pat);
      if (state == S_IDLE && start)
        fail_q <= 1'b0;
      else if (rd_pend && (mem_rdata != exp_q))
        fail_q <= 1'b1;
      case (state)
        S_IDLE: if (start) begin
          state <= S_RUN;
          elem  <= '0;
          step  <= '0;
          addr  <= '0;
        end
        S_RUN: begin
          if (!op_last) begin
            step <= step + 2'd1;
          end else begin
            step <= '0;
            if (!addr_end)
              addr <= is_down(elem) ? addr - AONE : addr + AONE;
            else if (elem == ELAST)
              state <= S_DRAIN;
            else begin
              elem <= elem_nx;
              addr <= is_down(elem_nx) ? ATOP : '0;
            end
          end
        end
        S_DRAIN: state <= S_FIN;
        default: if (!start) state <= S_IDLE;
      endcase
    end
  end

  assign mem_addr   = in_test ? addr : func_addr;
  assign mem_wdata  = in_test ? pattern(op_pat) : func_wdata;
  assign mem_we     = in_test ? ((state == S_RUN) && op_wr) : func_we;
  assign func_rdata = mem_rdata;
  assign done       = (state == S_FIN);
  assign fail       = fail_q;

  a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && step != 2'd0) |-> (mem_addr == $past(mem_addr)));

  a_r6_fail_from_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> $past(rd_pend));

  a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !(state == S_IDLE && start)) |=> fail);

  a_r7_fail_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start) |=> !fail);

  a_r8_done_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> done);

  a_r8_done_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(state == S_DRAIN));

  a_r3_drain_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DRAIN) |-> !mem_we);

endmodule

// File: tb/march_bist_test.sv
module march_bist_test;
  localparam int AW = 4;
  localparam int DW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int TOTAL = DEPTH * 18;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] func_addr = '0;
  logic [DW-1:0] func_wdata = '0;
  logic func_we = 0;
  logic [DW-1:0] func_rdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic mem_we, done, fail;

  int checks = 0, errors = 0, fault = 0;
  bit finished = 0;

  logic [DW-1:0] ram [DEPTH];
  logic [DW-1:0] wd, rd;

  logic [AW-1:0] log_addr [TOTAL+3];
  logic          log_we   [TOTAL+3];
  logic [DW-1:0] log_wd   [TOTAL+3];
  logic          log_fail [TOTAL+3];
  int            run_cycles;

  logic [AW-1:0] e_addr [TOTAL];
  logic          e_we   [TOTAL];
  logic [DW-1:0] e_wd   [TOTAL];

  always #2 clk = ~clk;

  march_bist #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .func_addr(func_addr), .func_wdata(func_wdata), .func_we(func_we),
    .func_rdata(func_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .done(done), .fail(fail));

  always @(posedge clk) begin
    if (mem_we) begin
      wd = mem_wdata;
      if (fault == 2 && mem_addr == 0) wd[1] = wd[0];
      ram[mem_addr] <= wd;
    end
    rd = ram[mem_addr];
    if (fault == 1 && mem_addr == 5) rd[0] = 1'b1;
    mem_rdata <= rd;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] bg(input int code);
    logic [DW-1:0] p;
    for (int i = 0; i < DW; i++)
      case (code)
        0: p[i] = 0;
        1: p[i] = 1;
        2: p[i] = (i % 2 == 0);
        3: p[i] = (i % 2 != 0);
        4: p[i] = (i % 4 == 0) || (i % 4 == 1);
        default: p[i] = (i % 4 == 2) || (i % 4 == 3);
      endcase
    return p;
  endfunction

  task automatic build_expected();
    int n = 0;
    int nops [8] = '{1, 2, 2, 2, 2, 1, 4, 4};
    int wr   [8][4] = '{'{1,0,0,0}, '{0,1,0,0}, '{0,1,0,0}, '{0,1,0,0},
                        '{0,1,0,0}, '{0,0,0,0}, '{1,0,1,0}, '{1,0,1,0}};
    int val  [8][4] = '{'{0,0,0,0}, '{0,1,0,0}, '{1,0,0,0}, '{0,1,0,0},
                        '{1,0,0,0}, '{0,0,0,0}, '{2,2,3,3}, '{4,4,5,5}};
    for (int e = 0; e < 8; e++)
      for (int i = 0; i < DEPTH; i++)
        for (int j = 0; j < nops[e]; j++) begin
          e_addr[n] = AW'((e == 3 || e == 4) ? DEPTH - 1 - i : i);
          e_we[n]   = wr[e][j] != 0;
          e_wd[n]   = bg(val[e][j]);
          n++;
        end
  endtask

  task automatic run_march();
    int n = 0;
    @(negedge clk);
    start = 1;
    func_we = 1;
    func_addr = AW'(9);
    func_wdata = '1;
    while (!done && n < TOTAL + 2) begin
      @(negedge clk);
      n++;
      if (n == TOTAL) func_we = 0;
      log_addr[n] = mem_addr;
      log_we[n]   = mem_we;
      log_wd[n]   = mem_wdata;
      log_fail[n] = fail;
    end
    run_cycles = n;
    func_we = 0;
  endtask

  task automatic t_reset();
    chk(done == 0, "R1", "done after reset", done, 0);
    chk(fail == 0, "R1", "fail after reset", fail, 0);
    func_addr = AW'(6);
    func_we = 1;
    #1;
    chk(mem_addr == AW'(6) && mem_we == 1, "R1", "collar follows functional",
        {mem_we, mem_addr}, {1'b1, AW'(6)});
    func_we = 0;
  endtask

  task automatic t_passthru();
    @(negedge clk);
    func_addr = AW'(3);
    func_wdata = 4'h9;
    func_we = 1;
    #1;
    chk(mem_wdata == 4'h9, "R2", "write data passes", mem_wdata, 9);
    @(negedge clk);
    func_we = 0;
    @(negedge clk);
    chk(func_rdata == 4'h9, "R2", "read data returns", func_rdata, 9);
  endtask

  task automatic t_good_run();
    int bad_we = 0, bad_addr = 0, bad_wd = 0;
    fault = 0;
    run_march();
    chk(run_cycles == TOTAL + 2, "R8", "cycles to done", run_cycles, TOTAL + 2);
    chk(log_we[TOTAL + 1] == 0, "R3", "no write after last op", log_we[TOTAL + 1], 0);
    for (int k = 0; k < TOTAL; k++) begin
      if (log_we[k + 1] != e_we[k]) bad_we++;
      if (log_addr[k + 1] != e_addr[k]) bad_addr++;
      if (e_we[k] && log_wd[k + 1] != e_wd[k]) bad_wd++;
    end
    chk(bad_we == 0, "R3", "operation kind mismatches", bad_we, 0);
    chk(bad_addr == 0, "R4", "address order mismatches", bad_addr, 0);
    chk(bad_wd == 0, "R5", "background mismatches", bad_wd, 0);
    chk(fail == 0, "R6", "fault-free run fail", fail, 0);
    repeat (4) @(negedge clk);
    chk(done == 1, "R8", "done holds with start", done, 1);
    start = 0;
    @(negedge clk);
    chk(done == 0, "R8", "done drops after start low", done, 0);
  endtask

  task automatic t_stuck_bit();
    fault = 1;
    run_march();
    chk(log_fail[28] == 0, "R6", "fail before compare", log_fail[28], 0);
    chk(log_fail[29] == 1, "R6", "fail after compare", log_fail[29], 1);
    chk(fail == 1, "R6", "stuck bit at done", fail, 1);
    start = 0;
    repeat (5) @(negedge clk);
    chk(fail == 1, "R7", "fail sticky while idle", fail, 1);
    fault = 0;
    run_march();
    chk(log_fail[1] == 0, "R7", "fail cleared at start", log_fail[1], 0);
    chk(fail == 0, "R7", "clean rerun", fail, 0);
    start = 0;
    @(negedge clk);
  endtask

  task automatic t_intra_word();
    fault = 2;
    run_march();
    chk(log_fail[163] == 0, "R5", "solid words miss in-word fault", log_fail[163], 0);
    chk(log_fail[164] == 1, "R5", "alternating word catches fault", log_fail[164], 1);
    start = 0;
    fault = 0;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    build_expected();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_passthru();
    t_good_run();
    t_stuck_bit();
    t_intra_word();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule